// File: doc/BRIEF.md
# Interlaced Field DMA Address Generator

This block produces the burst addresses for a DMA channel that stores an interlaced video frame in memory. Software sets a starting field base, a field count, a line count per field, a line length in bytes, a gap in bytes between lines, and a code that selects how many bursts each request moves. A start strobe captures the configuration and arms the channel. Each request pulse then yields one, two or four 16-byte bursts on a valid/ready address interface.

The walk has two levels. Within a line the address steps by 16 per burst. At a line boundary the next line begins one line length plus the gap after the start of the previous line. At a field boundary the field base moves forward by one line length, so each new field falls between the lines of the one before. After the last line of the last field the block sets a sticky DONE status bit and ignores requests until it is started again.

The control state machine has three states. IDLE means not armed. WAIT means armed and waiting for a request. ISSUE means bursts are being presented. Its transitions are: any state to WAIT on start; WAIT to ISSUE on a request; ISSUE to WAIT after the request's last burst is accepted; and ISSUE to IDLE when the accepted burst is the final one of the transfer, which also sets DONE.

Top module: `ilace_addr_gen`

## Requirements
- R1: After reset `bus_valid` and `busy` are 0 and `stat_rdata` reads 8'h00.
- R2: A pulse on `start` captures all configuration inputs and arms the block (`busy`=1). Requests made before any start produce no burst.
- R3: Each accepted request produces exactly as many bursts as the code in `cfg_bpr` selects: 2'b00 gives 1, 2'b01 gives 2, 2'b11 gives 4. After the last of them `bus_valid` is 0 until the next request.
- R4: Code 2'b10 is handled as one burst per request, and `cfg_err` reads 1 from the cycle after that start until the next start. For the other codes `cfg_err` reads 0.
- R5: Within a line the first burst address is the line start and each later burst adds 16. A line holds `cfg_bpl`/16 bursts.
- R6: The first burst of each following line within a field is at previous line start + `cfg_bpl` + `cfg_skip`.
- R7: Field k (counting from 0) starts at `cfg_base` + k*`cfg_bpl`, and its line count starts again from `cfg_lines`.
- R8: The transfer ends with the last burst of line `cfg_lines` in field `cfg_fields`. That acceptance sets DONE. After it, requests produce no burst until the next start.
- R9: `stat_rdata` carries DONE at bit 6 and 0 in every other bit. A status write with bit 6 = 1 clears DONE. A write with bit 6 = 0 leaves it unchanged. DONE stays set otherwise.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, the next cycle keeps `bus_valid` at 1 and `bus_addr` unchanged.
- R11: A request seen while bursts are being issued is ignored and adds no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures configuration and arms the channel |
| cfg_base | input | 32 | Field base address of the first field |
| cfg_fields | input | 16 | Fields per frame |
| cfg_lines | input | 16 | Lines per field |
| cfg_bpl | input | 16 | Bytes per line |
| cfg_skip | input | 16 | Bytes skipped between lines |
| cfg_bpr | input | 2 | Bursts-per-request code |
| req | input | 1 | Transfer request |
| bus_addr | output | 32 | Burst address |
| bus_valid | output | 1 | Burst address valid |
| bus_ready | input | 1 | Burst accepted when high with valid |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data (bit 6 clears DONE) |
| stat_rdata | output | 8 | Status register value |
| busy | output | 1 | Channel armed or issuing |
| cfg_err | output | 1 | Reserved burst code was captured |

## Verification
The hardest point to reach from the ports is the field boundary, where the line counter reloads and the field base moves by one line length. Most of all it is the final burst, which must land exactly where the field counter runs out. The stimulus table therefore uses several fields and several lines in every entry, with line lengths of 1, 2, 4 and 8 bursts. Each entry is run to completion with request pulses spanning two cycles and periodic ready stalls. Every address is compared with a nested field/line/burst loop, and the stimulus then confirms that extra requests after DONE stay silent.

// File: rtl/iag_pkg.sv
package iag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE
    } iag_state_e;

    localparam int unsigned BURST_LG = 4;
    localparam int unsigned MAX_BURSTS = 4;
    localparam int unsigned NB_W = $clog2(MAX_BURSTS + 1);
endpackage

// File: rtl/iag_bpr_decode.sv
module iag_bpr_decode
    import iag_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [1:0]      code,
    output logic [NB_W-1:0] nbursts,
    output logic            err
);
    logic [1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= 2'b00;
        end else if (load) begin
            code_q <= code;
        end
    end

    always_comb begin
        err = 1'b0;
        unique case (code_q)
            2'b00: nbursts = NB_W'(1);
            2'b01: nbursts = NB_W'(2);
            2'b11: nbursts = NB_W'(4);
            default: begin
                nbursts = NB_W'(1);
                err     = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/iag_walker.sv
module iag_walker
    import iag_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] fields,
    input  logic [CW-1:0] lines,
    input  logic [CW-1:0] bpl,
    input  logic [CW-1:0] skip,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [CW:0] STEP = (CW+1)'(1 << BURST_LG);

    logic [AW-1:0] fb_q, la_q;
    logic [CW-1:0] off_q, lcnt_q, fcnt_q;
    logic [CW-1:0] bpl_q, skip_q, lines_q;
    logic          eol, eof;
    logic [AW-1:0] fb_next;

    assign eol     = ({1'b0, off_q} + STEP) >= {1'b0, bpl_q};
    assign eof     = eol && (lcnt_q <= CW'(1));
    assign last    = eof && (fcnt_q <= CW'(1));
    assign addr    = la_q + AW'(off_q);
    assign fb_next = fb_q + AW'(bpl_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q    <= '0;
            la_q    <= '0;
            off_q   <= '0;
            lcnt_q  <= '0;
            fcnt_q  <= '0;
            bpl_q   <= '0;
            skip_q  <= '0;
            lines_q <= '0;
        end else if (load) begin
            fb_q    <= base;
            la_q    <= base;
            off_q   <= '0;
            lcnt_q  <= lines;
            fcnt_q  <= fields;
            bpl_q   <= bpl;
            skip_q  <= skip;
            lines_q <= lines;
        end else if (adv) begin
            if (!eol) begin
                off_q <= off_q + CW'(STEP);
            end else begin
                off_q <= '0;
                if (eof) begin
                    fb_q   <= fb_next;
                    la_q   <= fb_next;
                    lcnt_q <= lines_q;
                    fcnt_q <= (fcnt_q == '0) ? '0 : fcnt_q - CW'(1);
                end else begin
                    la_q   <= la_q + AW'(bpl_q) + AW'(skip_q);
                    lcnt_q <= lcnt_q - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/iag_ctrl.sv
module iag_ctrl
    import iag_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            req,
    input  logic            bus_ready,
    input  logic            last,
    input  logic [NB_W-1:0] nbursts,
    output logic            bus_valid,
    output logic            busy,
    output logic            adv,
    output logic            done_set
);
    iag_state_e      state_q, state_nx;
    logic [NB_W-1:0] left_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  state_nx = ST_IDLE;
            ST_WAIT:  if (req) state_nx = ST_ISSUE;
            ST_ISSUE: begin
                if (bus_ready) begin
                    if (last)                     state_nx = ST_IDLE;
                    else if (left_q == NB_W'(1))  state_nx = ST_WAIT;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
        if (start) state_nx = ST_WAIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_WAIT && req && !start) begin
                left_q <= nbursts;
            end else if (adv) begin
                left_q <= left_q - NB_W'(1);
            end
        end
    end

    always_comb begin
        bus_valid = (state_q == ST_ISSUE);
        busy      = (state_q != ST_IDLE);
        adv       = bus_valid && bus_ready && !start;
        done_set  = adv && last;
    end
endmodule

// File: rtl/iag_status.sv
module iag_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int unsigned DONE_BIT = 6;
    logic done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (set) begin
            done_q <= 1'b1;
        end else if (wr && wdata[DONE_BIT]) begin
            done_q <= 1'b0;
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[DONE_BIT] = done_q;
    end
endmodule

// File: rtl/ilace_addr_gen.sv
module ilace_addr_gen
    import iag_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_fields,
    input  logic [CW-1:0] cfg_lines,
    input  logic [CW-1:0] cfg_bpl,
    input  logic [CW-1:0] cfg_skip,
    input  logic [1:0]    cfg_bpr,
    input  logic          req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_valid,
    input  logic          bus_ready,
    input  logic          stat_wr,
    input  logic [7:0]    stat_wdata,
    output logic [7:0]    stat_rdata,
    output logic          busy,
    output logic          cfg_err
);
    logic [NB_W-1:0] nbursts;
    logic            last, adv, done_set;

    iag_bpr_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .code    (cfg_bpr),
        .nbursts (nbursts),
        .err     (cfg_err)
    );

    iag_walker #(.AW(AW), .CW(CW)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .adv    (adv),
        .base   (cfg_base),
        .fields (cfg_fields),
        .lines  (cfg_lines),
        .bpl    (cfg_bpl),
        .skip   (cfg_skip),
        .addr   (bus_addr),
        .last   (last)
    );

    iag_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req       (req),
        .bus_ready (bus_ready),
        .last      (last),
        .nbursts   (nbursts),
        .bus_valid (bus_valid),
        .busy      (busy),
        .adv       (adv),
        .done_set  (done_set)
    );

    iag_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (done_set),
        .wr    (stat_wr),
        .wdata (stat_wdata),
        .rdata (stat_rdata)
    );
endmodule

// File: rtl/iag_checker.sv
module iag_checker #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    cfg_bpr,
    input logic [AW-1:0] bus_addr,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic          stat_wr,
    input logic [7:0]    stat_wdata,
    input logic [7:0]    stat_rdata,
    input logic          busy,
    input logic          cfg_err
);
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready && !start) |=> (bus_valid && $stable(bus_addr))); // R10

    AST_STAT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[7] == 1'b0) && (stat_rdata[5:0] == 6'd0)); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[6] && !(stat_wr && stat_wdata[6])) |=> stat_rdata[6]); // R9

    AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[6]) |-> $past(bus_valid && bus_ready)); // R8

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[6]) |-> !bus_valid); // R8

    AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (cfg_err == ($past(cfg_bpr) == 2'b10))); // R4

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid); // R2
endmodule

bind ilace_addr_gen iag_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_bpr    (cfg_bpr),
    .bus_addr   (bus_addr),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .stat_rdata (stat_rdata),
    .busy       (busy),
    .cfg_err    (cfg_err)
);

// File: tb/ilace_addr_gen_test.sv
module ilace_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n, start, req, bus_ready, stat_wr;
    logic [31:0] cfg_base, bus_addr;
    logic [15:0] cfg_fields, cfg_lines, cfg_bpl, cfg_skip;
    logic [1:0]  cfg_bpr;
    logic [7:0]  stat_wdata, stat_rdata;
    logic        bus_valid, busy, cfg_err;

    always #10 clk = ~clk;

    ilace_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_fields(cfg_fields), .cfg_lines(cfg_lines), .cfg_bpl(cfg_bpl),
        .cfg_skip(cfg_skip), .cfg_bpr(cfg_bpr), .req(req), .bus_addr(bus_addr),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .busy(busy),
        .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] nf;
        logic [15:0] nl;
        logic [15:0] bpl;
        logic [15:0] skip;
        logic [1:0]  code;
        logic [2:0]  k;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 16'd2, 16'd3, 16'd32,  16'd16, 2'b00, 3'd1},
        '{32'h8000_0000, 16'd3, 16'd2, 16'd64,  16'd0,  2'b01, 3'd2},
        '{32'h0000_0020, 16'd2, 16'd2, 16'd128, 16'd64, 2'b11, 3'd4},
        '{32'h0000_4000, 16'd2, 16'd4, 16'd16,  16'd48, 2'b10, 3'd1}
    };

    int          errors = 0;
    int          checks = 0;
    int          tick   = 0;
    int          n_exp, idx;
    logic [31:0] expq [64];
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build(input vec_t v);
        logic [31:0] la;
        n_exp = 0;
        for (int f = 0; f < int'(v.nf); f++) begin
            la = v.base + 32'(f) * 32'(v.bpl);
            for (int l = 0; l < int'(v.nl); l++) begin
                for (int b = 0; b < int'(v.bpl) / 16; b++) begin
                    expq[n_exp] = la + 32'(16 * b);
                    n_exp++;
                end
                la = la + 32'(v.bpl) + 32'(v.skip);
            end
        end
    endtask

    task automatic do_start(input vec_t v);
        @(negedge clk);
        cfg_base = v.base; cfg_fields = v.nf; cfg_lines = v.nl;
        cfg_bpl = v.bpl; cfg_skip = v.skip; cfg_bpr = v.code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic quiet_req(input string tag);
        int seen;
        seen = 0;
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (bus_valid) seen++;
            @(negedge clk);
        end
        check(seen == 0, tag, 32'(seen), 32'd0);
    endtask

    task automatic do_req(input int k);
        int got, guard;
        got = 0; guard = 0;
        @(negedge clk) req = 1'b1;
        @(negedge clk);
        while (got < k && guard < 40) begin
            if (guard > 0) req = 1'b0;
            bus_ready = (tick % 3 != 2);
            tick++;
            if (bus_valid && bus_ready) begin
                check(bus_addr == expq[idx], "R5 R6 R7 address", bus_addr, expq[idx]);
                idx++;
                got++;
            end
            @(negedge clk);
            guard++;
        end
        req = 1'b0;
        bus_ready = 1'b1;
        check(got == k, "R3 bursts per request", 32'(got), 32'(k));
        check(!bus_valid, "R11 no extra burst", 32'(bus_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; req = 1'b0; bus_ready = 1'b1;
        stat_wr = 1'b0; stat_wdata = '0;
        cfg_base = '0; cfg_fields = '0; cfg_lines = '0;
        cfg_bpl = '0; cfg_skip = '0; cfg_bpr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!bus_valid, "R1 valid", 32'(bus_valid), 32'd0);
        check(!busy, "R1 busy", 32'(busy), 32'd0);
        check(stat_rdata == 8'h00, "R1 status", 32'(stat_rdata), 32'd0);

        // R2: request before any start is ignored
        quiet_req("R2 request before start");
        check(!busy, "R2 not armed", 32'(busy), 32'd0);

        for (int v = 0; v < NV; v++) begin
            build(VEC[v]);
            do_start(VEC[v]);
            check(busy, "R2 armed", 32'(busy), 32'd1);
            check(cfg_err == (VEC[v].code == 2'b10), "R4 error flag",
                  32'(cfg_err), 32'(VEC[v].code == 2'b10));
            idx = 0;
            for (int r = 0; r < n_exp / int'(VEC[v].k); r++) do_req(int'(VEC[v].k));
            check(idx == n_exp, "R8 burst total", 32'(idx), 32'(n_exp));
            check(stat_rdata == 8'h40, "R8 done set", 32'(stat_rdata), 32'h40);
            check(!busy, "R8 idle after done", 32'(busy), 32'd0);
            quiet_req("R8 request after done");

            // R9: writing zero keeps DONE, writing one clears it
            @(negedge clk) begin stat_wr = 1'b1; stat_wdata = 8'hBF; end
            @(negedge clk) stat_wr = 1'b0;
            check(stat_rdata == 8'h40, "R9 write zero", 32'(stat_rdata), 32'h40);
            @(negedge clk) begin stat_wr = 1'b1; stat_wdata = 8'h40; end
            @(negedge clk) stat_wr = 1'b0;
            check(stat_rdata == 8'h00, "R9 write one", 32'(stat_rdata), 32'h00);
        end

        // R10: stalled burst keeps its address
        build(VEC[0]);
        do_start(VEC[0]);
        @(negedge clk) begin req = 1'b1; bus_ready = 1'b0; end
        @(negedge clk) req = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_valid, "R10 valid held", 32'(bus_valid), 32'd1);
        check(bus_addr == expq[0], "R10 address held", bus_addr, expq[0]);
        bus_ready = 1'b1;
        @(negedge clk);
        check(!bus_valid, "R3 single burst then wait", 32'(bus_valid), 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule